// File: doc/BRIEF.md
# Pre-Update Weight Accumulation Window

This block sits in front of a read-modify-write counter memory, for example one row of a frequency-estimation sketch. It takes a stream of (key, weight) items, where the key is the counter address. It guarantees that the memory never sees the same address twice within a short distance, so a memory with a few cycles of read latency can update one item per cycle without forwarding logic.

Items pass through a window of `DEPTH` slots. When an item reaches the oldest slot and carries a nonzero weight, every younger item in the window with the same key has its weight added to it, and those younger items are set to weight zero. An item whose weight is zero when it leaves is a bubble. It is presented with `out_valid_o` low, so no memory access is made for it. The window advances only when an input item is accepted. At the end of a burst, `DEPTH` zero-weight padding items drain it, and the padding may use any key.

Top module: `wacc_window`

## Requirements
- R1: After reset every slot holds key 0 with weight 0, so the first `DEPTH` accepted items produce bubbles (`out_valid_o` low, `out_key_o` 0).
- R2: Items leave in arrival order. An item accepted on one transfer is presented at the output during the `DEPTH`-th later transfer.
- R3: When the oldest slot has a nonzero weight, `out_wt_o` is its weight plus the weights of all younger slots with an equal key. On the transfer, those younger slots become weight 0 and keep their keys.
- R4: `out_valid_o` is high only when `in_valid_i` is high and the oldest slot has a nonzero weight. A zero-weight oldest slot is dropped as a bubble on the transfer, and `out_wt_o` reads 0 while it is presented.
- R5: Among valid outputs, the same key never appears twice within any `DEPTH` consecutive transfers.
- R6: The folded weight saturates at 2^`WT_W`-1 and does not wrap.
- R7: A transfer occurs only when `in_valid_i` and `out_ready_i` are both high, and `in_ready_o` equals `out_ready_i`. Without a transfer the window is frozen, so `out_key_o` and `out_wt_o` hold.
- R8: When no sum saturates, after `DEPTH` padding items of weight 0 (any key) the total output weight per key equals the total input weight per key.
- R9: A zero-weight oldest slot folds nothing. A younger item with the same key keeps its weight and is emitted when it reaches the oldest slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input item present |
| in_ready_o | output | 1 | Input item can be taken |
| in_key_i | input | KEY_W | Counter address of the input item |
| in_wt_i | input | WT_W | Weight of the input item; 0 acts as padding |
| out_valid_o | output | 1 | Output item is a real update (not a bubble) |
| out_ready_i | input | 1 | Downstream can take an item |
| out_key_o | output | KEY_W | Counter address of the oldest slot |
| out_wt_o | output | WT_W | Folded weight of the oldest slot |

## Verification
The bench builds the window with `DEPTH`=4, `KEY_W`=16 and `WT_W`=8. The short window makes bubbles, refills and flushes frequent within a few thousand cycles. The narrow weight lets two items drive a fold to the 255 saturation limit. Random streams are skewed towards four hot keys, so folds of up to the full window occur often, and random stalls on both handshake sides exercise the frozen state. The padding is deliberately given a hot key, which shows that real weight is not absorbed into padding.

// File: rtl/wacc_pkg.sv
package wacc_pkg;
  localparam int unsigned DEPTH_DEF = 8;
  localparam int unsigned KEY_W_DEF = 32;
  localparam int unsigned WT_W_DEF  = 32;

  // width needed to add depth values of wt_w bits without overflow
  function automatic int unsigned sum_width(input int unsigned depth, input int unsigned wt_w);
    int unsigned w;
    w = 0;
    while ((1 << w) < depth) w++;
    return wt_w + w;
  endfunction
endpackage

// File: rtl/wacc_match.sv
module wacc_match #(
  parameter int unsigned DEPTH = wacc_pkg::DEPTH_DEF,
  parameter int unsigned KEY_W = wacc_pkg::KEY_W_DEF
) (
  input  logic [DEPTH-1:0][KEY_W-1:0] keys_i,
  output logic [DEPTH-2:0]            hit_o
);
  localparam int unsigned HEAD = DEPTH - 1;

  for (genvar g = 0; g < DEPTH - 1; g++) begin : g_cmp
    assign hit_o[g] = (keys_i[g] == keys_i[HEAD]);
  end
endmodule

// File: rtl/wacc_fold.sv
module wacc_fold #(
  parameter int unsigned DEPTH = wacc_pkg::DEPTH_DEF,
  parameter int unsigned WT_W  = wacc_pkg::WT_W_DEF
) (
  input  logic [DEPTH-1:0][WT_W-1:0] wts_i,
  input  logic [DEPTH-2:0]           sel_i,
  output logic [WT_W-1:0]            sum_o
);
  localparam int unsigned HEAD = DEPTH - 1;
  localparam int unsigned SW   = wacc_pkg::sum_width(DEPTH, WT_W);
  localparam logic [SW-1:0] MAX_W = SW'({WT_W{1'b1}});

  logic [SW-1:0] acc;

  always_comb begin
    acc = SW'(wts_i[HEAD]);
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (sel_i[i]) acc = acc + SW'(wts_i[i]);
    end
  end

  assign sum_o = (acc > MAX_W) ? {WT_W{1'b1}} : acc[WT_W-1:0];
endmodule

// File: rtl/wacc_shift.sv
module wacc_shift #(
  parameter int unsigned DEPTH = wacc_pkg::DEPTH_DEF,
  parameter int unsigned KEY_W = wacc_pkg::KEY_W_DEF,
  parameter int unsigned WT_W  = wacc_pkg::WT_W_DEF
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        adv_i,
  input  logic [KEY_W-1:0]            key_i,
  input  logic [WT_W-1:0]             wt_i,
  input  logic [DEPTH-2:0]            clr_i,
  output logic [DEPTH-1:0][KEY_W-1:0] keys_o,
  output logic [DEPTH-1:0][WT_W-1:0]  wts_o
);
  // slot 0 is the youngest, slot DEPTH-1 the oldest
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      keys_o[0] <= '0;
      wts_o[0]  <= '0;
    end else if (adv_i) begin
      keys_o[0] <= key_i;
      wts_o[0]  <= wt_i;
    end
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        keys_o[g] <= '0;
        wts_o[g]  <= '0;
      end else if (adv_i) begin
        keys_o[g] <= keys_o[g-1];
        wts_o[g]  <= clr_i[g-1] ? '0 : wts_o[g-1];
      end
    end
  end
endmodule

// File: rtl/wacc_window.sv
module wacc_window #(
  parameter int unsigned DEPTH = wacc_pkg::DEPTH_DEF,
  parameter int unsigned KEY_W = wacc_pkg::KEY_W_DEF,
  parameter int unsigned WT_W  = wacc_pkg::WT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [KEY_W-1:0] in_key_i,
  input  logic [WT_W-1:0]  in_wt_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [KEY_W-1:0] out_key_o,
  output logic [WT_W-1:0]  out_wt_o
);
  localparam int unsigned HEAD = DEPTH - 1;

  logic [DEPTH-1:0][KEY_W-1:0] keys;
  logic [DEPTH-1:0][WT_W-1:0]  wts;
  logic [DEPTH-2:0]            hit, fold_sel;
  logic [WT_W-1:0]             sum;
  logic                        head_live, adv;

  assign adv       = in_valid_i & out_ready_i;
  assign head_live = |wts[HEAD];
  // a dead head must not absorb younger same-key weight
  assign fold_sel  = hit & {(DEPTH-1){head_live}};

  wacc_match #(.DEPTH(DEPTH), .KEY_W(KEY_W)) i_match (
    .keys_i (keys),
    .hit_o  (hit)
  );

  wacc_fold #(.DEPTH(DEPTH), .WT_W(WT_W)) i_fold (
    .wts_i (wts),
    .sel_i (fold_sel),
    .sum_o (sum)
  );

  wacc_shift #(.DEPTH(DEPTH), .KEY_W(KEY_W), .WT_W(WT_W)) i_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .key_i  (in_key_i),
    .wt_i   (in_wt_i),
    .clr_i  (fold_sel),
    .keys_o (keys),
    .wts_o  (wts)
  );

  assign in_ready_o  = out_ready_i;
  assign out_valid_o = in_valid_i & head_live;
  assign out_key_o   = keys[HEAD];
  assign out_wt_o    = head_live ? sum : '0;
endmodule

// File: rtl/wacc_window_chk.sv
module wacc_window_chk #(
  parameter int unsigned DEPTH = wacc_pkg::DEPTH_DEF,
  parameter int unsigned KEY_W = wacc_pkg::KEY_W_DEF,
  parameter int unsigned WT_W  = wacc_pkg::WT_W_DEF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [KEY_W-1:0] in_key_i,
  input logic [WT_W-1:0]  in_wt_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [KEY_W-1:0] out_key_o,
  input logic [WT_W-1:0]  out_wt_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic                        xfer;
  logic [CW-1:0]               n_xfer;
  logic [DEPTH-2:0][KEY_W-1:0] hist_key;
  logic [DEPTH-2:0]            hist_vld;
  logic                        recent_hit;

  assign xfer = in_valid_i & out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_xfer   <= '0;
      hist_key <= '0;
      hist_vld <= '0;
    end else if (xfer) begin
      if (n_xfer < CW'(DEPTH)) n_xfer <= n_xfer + 1'b1;
      hist_key[0] <= out_key_o;
      hist_vld[0] <= out_valid_o;
      for (int i = 1; i < DEPTH - 1; i++) begin
        hist_key[i] <= hist_key[i-1];
        hist_vld[i] <= hist_vld[i-1];
      end
    end
  end

  always_comb begin
    recent_hit = 1'b0;
    for (int i = 0; i < DEPTH - 1; i++)
      if (hist_vld[i] && hist_key[i] == out_key_o) recent_hit = 1'b1;
  end

  p_reset_empty_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_xfer < CW'(DEPTH)) |-> !out_valid_o);

  p_valid_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_wt_o != '0) && in_valid_i);

  p_key_spacing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i) |-> !recent_hit);

  p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer |=> $stable(out_key_o) && $stable(out_wt_o));

  p_ready_mirror_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o == out_ready_i);
endmodule

bind wacc_window wacc_window_chk #(.DEPTH(DEPTH), .KEY_W(KEY_W), .WT_W(WT_W)) i_wacc_window_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_key_i    (in_key_i),
  .in_wt_i     (in_wt_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_key_o   (out_key_o),
  .out_wt_o    (out_wt_o)
);

// File: tb/test_wacc_window.sv
module test_wacc_window;
  localparam int DEPTH = 4;
  localparam int KEY_W = 16;
  localparam int WT_W  = 8;
  localparam int MAXW  = (1 << WT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [KEY_W-1:0] in_key = '0;
  logic [WT_W-1:0]  in_wt = '0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [KEY_W-1:0] out_key;
  logic [WT_W-1:0]  out_wt;

  always #5 clk = ~clk;

  wacc_window #(.DEPTH(DEPTH), .KEY_W(KEY_W), .WT_W(WT_W)) i_wacc_window (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_key_i    (in_key),
    .in_wt_i     (in_wt),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_key_o   (out_key),
    .out_wt_o    (out_wt)
  );

  typedef struct { int key; int wt; } ent_t;
  ent_t win[$];          // index 0 = oldest
  int   n_cmp = 0, n_bad = 0, n_adv = 0;
  int   last_adv[int];
  longint in_tot[int], out_tot[int];
  bit   done = 1'b0;

  task automatic fail(input string req, input string what, input longint act, input longint exp);
    n_bad++;
    $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
  endtask

  task automatic step(input bit v, input int k, input int w, input bit r, input string tag);
    bit exp_v; int exp_k; int exp_w; longint s;
    @(negedge clk);
    in_valid = v; in_key = k[KEY_W-1:0]; in_wt = w[WT_W-1:0]; out_ready = r;
    #1;
    exp_k = win[0].key;
    if (win[0].wt != 0) begin
      s = win[0].wt;
      for (int i = 1; i < win.size(); i++) if (win[i].key == exp_k) s += win[i].wt;
      exp_w = (s > MAXW) ? MAXW : int'(s);
    end else exp_w = 0;
    exp_v = v && (win[0].wt != 0);
    n_cmp++;
    if (out_valid !== exp_v)              fail(tag, "out_valid", out_valid, exp_v);
    else if (int'(out_key) != exp_k)      fail(tag, "out_key", out_key, exp_k);
    else if (int'(out_wt) != exp_w)       fail(tag, "out_wt", out_wt, exp_w);
    else if (in_ready !== r)              fail("R7", "in_ready", in_ready, r);
    else n_cmp = n_cmp;
    if (v && r) begin
      if (exp_v) begin
        n_cmp++;  // R5 spacing
        if (last_adv.exists(exp_k) && (n_adv - last_adv[exp_k]) < DEPTH)
          fail("R5", "key gap", n_adv - last_adv[exp_k], DEPTH);
        last_adv[exp_k] = n_adv;
        if (!out_tot.exists(exp_k)) out_tot[exp_k] = 0;
        out_tot[exp_k] += exp_w;
      end
      if (win[0].wt != 0)
        for (int i = 1; i < win.size(); i++) if (win[i].key == exp_k) win[i].wt = 0;
      void'(win.pop_front());
      win.push_back('{key: k, wt: w});
      if (!in_tot.exists(k)) in_tot[k] = 0;
      in_tot[k] += w;
      n_adv++;
    end
  endtask

  task automatic flush(input int pad_key, input string tag);
    for (int i = 0; i < DEPTH; i++) step(1'b1, pad_key, 0, 1'b1, tag);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) win.push_back('{key: 0, wt: 0});
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents come out as bubbles
    for (int i = 0; i < DEPTH; i++) step(1'b1, 20 + i, 1, 1'b1, "R1");
    flush(5, "R2");
    // R2: ordering and latency, distinct keys
    for (int i = 0; i < 2 * DEPTH; i++) step(1'b1, 100 + i, i + 1, 1'b1, "R2");
    flush(7, "R2");
    // R3: fold same key inside the window
    step(1'b1, 3, 2, 1'b1, "R3");
    step(1'b1, 3, 4, 1'b1, "R3");
    step(1'b1, 8, 1, 1'b1, "R3");
    step(1'b1, 3, 7, 1'b1, "R3");
    flush(9, "R3");
    // R4: zero-weight items are bubbles
    step(1'b1, 11, 0, 1'b1, "R4");
    step(1'b1, 12, 0, 1'b1, "R4");
    flush(11, "R4");
    // R9: dead head does not absorb
    step(1'b1, 7, 0, 1'b1, "R9");
    step(1'b1, 7, 4, 1'b1, "R9");
    flush(1, "R9");
    // R6: saturation
    step(1'b1, 9, 200, 1'b1, "R6");
    step(1'b1, 9, 100, 1'b1, "R6");
    step(1'b1, 9, 90, 1'b1, "R6");
    flush(2, "R6");
    // R7: stalls on each side
    step(1'b1, 4, 5, 1'b1, "R7");
    step(1'b1, 4, 6, 1'b0, "R7");
    step(1'b0, 4, 6, 1'b1, "R7");
    step(1'b0, 4, 6, 1'b0, "R7");
    flush(3, "R7");

    // R8: random skewed stream with stalls, per-key totals
    in_tot.delete(); out_tot.delete();
    for (int n = 0; n < 3000; n++) begin
      int k; int w; bit v; bit r;
      k = ($urandom_range(0, 9) < 8) ? int'($urandom_range(0, 3)) : int'($urandom_range(4, 63));
      w = ($urandom_range(0, 9) == 0) ? 0 : int'($urandom_range(1, 15));
      v = ($urandom_range(0, 7) != 0);
      r = ($urandom_range(0, 7) != 0);
      step(v, k, w, r, "R3");
    end
    flush(1, "R8");
    foreach (in_tot[k]) begin
      longint o;
      o = out_tot.exists(k) ? out_tot[k] : 0;
      n_cmp++;
      if (o != in_tot[k]) fail("R8", $sformatf("total key %0d", k), o, in_tot[k]);
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule